// File: doc/BRIEF.md
# Serial In-System Programming Controller

This block is the serial port through which a configuration array is written and read back while the chip stays on its board. It uses five pins: an active-low enable, serial data in, serial data out, a serial clock and a mode pin. Four of these pins are shared. While the enable is high they are ordinary general-purpose inputs and are passed straight to the core logic. While the enable is low they form the programming port. The serial clock is sampled by the system clock, and each rising serial-clock edge advances the port by one step.

Inside the port are three registers. A 5-bit instruction register is filled while the port is idle. A row-select register, one bit per array row, chooses the rows to act on. A data register, two halves wide, carries one row's worth of bits. A three-state controller moves between idle, shift and execute. While the mode pin is high, the serial data value on each edge picks the next state. While the mode pin is low, the state holds, and in the shift state the register named by the instruction moves one bit. Execution happens on the step from shift to execute. It can write the data register into all selected rows, copy a single selected row back into the data register, or load the 8-bit identifier 0x03 for reading out.

Top module: `isp_ctrl`

## Requirements
- R1: While `prog_en_n` is 1, `user_in` equals {pin_sclk, pin_sdo_in, pin_mode, pin_sdi} (bit 0 is pin_sdi), and serial-clock edges change no port register. While `prog_en_n` is 0, `user_in` is 0.
- R2: `sdo_oe` is 1 exactly while `prog_en_n` is 0.
- R3: In idle with mode 0, each rising serial-clock edge shifts serial data into instruction bit 4 and moves the register toward bit 0, so five edges load an instruction least significant bit first. Codes: 1 row-select shift, 2 data shift, 3 program rows, 4 verify row, 5 read identifier.
- R4: With mode 1, a serial-clock edge moves idle→shift when data is 1 (else stays idle), shift→execute when data is 1 (else idle), and execute→shift when data is 1 (else idle).
- R5: In shift under code 1, the 108-bit row-select register takes serial data into bit 107 and shifts toward bit 0; `sdo` shows bit 0.
- R6: In shift under code 2, the 320-bit data register takes serial data into bit 319 (upper half) and shifts toward bit 0 (lower half); `sdo` shows bit 0.
- R7: Entering execute under code 3 writes the data register into every row whose select bit is 1, and leaves all other rows unchanged.
- R8: Entering execute under code 4 copies the selected row into the data register when exactly one select bit is 1. With no bits or several bits set, the data register is unchanged.
- R9: Entering execute under code 5 loads the identifier 0x03. In shift under code 5, that register shifts out least significant bit first on `sdo`.
- R10: When `prog_en_n` goes to 1, the state returns to idle and the instruction clears. The row-select, data and identifier registers and the array keep their contents.
- R11: `sdo` is 0 in idle and execute, and in shift under any code other than 1, 2 or 5.
- R12: An instruction code outside 1..5 shifts nothing and executes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (clears the array too) |
| prog_en_n | input | 1 | Programming enable, active low |
| pin_sdi | input | 1 | Serial data in / general input 0 |
| pin_mode | input | 1 | Mode control / general input 1 |
| pin_sdo_in | input | 1 | Input side of the shared serial-out pin / general input 2 |
| pin_sclk | input | 1 | Serial clock / general input 3 |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the serial-out pin |
| user_in | output | 4 | Shared pins passed to the core logic when not programming |

## Verification
The hardest case to reach is verify-row reading back the one row selected out of 108. Getting there takes a full program pass first: a row select with two bits set, then a 320-bit pattern, then execute. After that the bench shifts in a second data pattern, selects a single row and verifies, so the only way the first pattern can come back is through the array. The bench also repeats the verify with no select bits and with two select bits, and shifts out all 320 bits each time so that every bit of the restored or kept row is compared on `sdo`.

// File: rtl/isp_pkg.sv
package isp_pkg;

    localparam int OP_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_EXEC  = 2'd2
    } isp_state_e;

    localparam logic [OP_W-1:0] OP_ADDR   = 5'h01;
    localparam logic [OP_W-1:0] OP_DATA   = 5'h02;
    localparam logic [OP_W-1:0] OP_PROG   = 5'h03;
    localparam logic [OP_W-1:0] OP_VERIFY = 5'h04;
    localparam logic [OP_W-1:0] OP_READID = 5'h05;

    // one-cycle execute strobes
    typedef struct packed {
        logic prog;
        logic verify;
        logic readid;
    } isp_cmd_t;

    // which register moves in the shift state
    typedef struct packed {
        logic addr;
        logic data;
        logic id;
    } isp_sel_t;

    function automatic isp_state_e step_state(isp_state_e cur, logic sdi);
        case (cur)
            ST_IDLE:  return sdi ? ST_SHIFT : ST_IDLE;
            ST_SHIFT: return sdi ? ST_EXEC  : ST_IDLE;
            default:  return sdi ? ST_SHIFT : ST_IDLE;
        endcase
    endfunction

    function automatic isp_sel_t decode_sel(logic [OP_W-1:0] op);
        isp_sel_t s;
        s.addr = (op == OP_ADDR);
        s.data = (op == OP_DATA);
        s.id   = (op == OP_READID);
        return s;
    endfunction

endpackage

// File: rtl/isp_fsm.sv
module isp_fsm
    import isp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en_n,
    input  logic            rise,
    input  logic            mode,
    input  logic            sdi,
    output isp_state_e      state_o,
    output logic [OP_W-1:0] instr_o,
    output isp_sel_t        shift_o,
    output isp_cmd_t        cmd_o
);

    isp_state_e      state_q;
    logic [OP_W-1:0] instr_q;
    logic            step;
    logic            go_exec;
    isp_sel_t        sel;

    assign step = rise & ~en_n;

    always_ff @(posedge clk) begin
        if (rst || en_n) begin
            state_q <= ST_IDLE;
            instr_q <= '0;
        end else if (rise) begin
            if (mode)
                state_q <= step_state(state_q, sdi);
            else if (state_q == ST_IDLE)
                instr_q <= {sdi, instr_q[OP_W-1:1]};
        end
    end

    always_comb begin
        sel     = decode_sel(instr_q);
        go_exec = step & mode & sdi & (state_q == ST_SHIFT);
        shift_o.addr = step & ~mode & (state_q == ST_SHIFT) & sel.addr;
        shift_o.data = step & ~mode & (state_q == ST_SHIFT) & sel.data;
        shift_o.id   = step & ~mode & (state_q == ST_SHIFT) & sel.id;
        cmd_o.prog   = go_exec & (instr_q == OP_PROG);
        cmd_o.verify = go_exec & (instr_q == OP_VERIFY);
        cmd_o.readid = go_exec & (instr_q == OP_READID);
    end

    assign state_o = state_q;
    assign instr_o = instr_q;

endmodule

// File: rtl/isp_sreg.sv
module isp_sreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         sdi,
    output logic [W-1:0] q
);

    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst)
            q_r <= '0;
        else if (load_en)
            q_r <= load_val;
        else if (shift_en)
            q_r <= {sdi, q_r[W-1:1]};
    end

    assign q = q_r;

endmodule

// File: rtl/isp_array.sv
module isp_array #(
    parameter int ROWS  = 108,
    parameter int WIDTH = 320
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [ROWS-1:0]  row_sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] cells [ROWS];

    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            if (rst)
                cells[r] <= '0;
            else if (wr_en && row_sel[r])
                cells[r] <= wdata;
        end
    end

    // meaningful only when row_sel is one-hot; caller gates the load
    always_comb begin
        rdata = '0;
        for (int r = 0; r < ROWS; r++)
            if (row_sel[r])
                rdata = cells[r];
    end

endmodule

// File: rtl/isp_ctrl.sv
module isp_ctrl
    import isp_pkg::*;
#(
    parameter int ROWS  = 108,
    parameter int HALF  = 160,
    parameter int ID_W  = 8,
    parameter logic [ID_W-1:0] ID_VAL = 8'h03
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       prog_en_n,
    input  logic       pin_sdi,
    input  logic       pin_mode,
    input  logic       pin_sdo_in,
    input  logic       pin_sclk,
    output logic       sdo,
    output logic       sdo_oe,
    output logic [3:0] user_in
);

    localparam int DW = 2 * HALF;

    logic            sclk_q;
    logic            rise;
    isp_state_e      state;
    logic [OP_W-1:0] instr;
    isp_sel_t        shift;
    isp_cmd_t        cmd;
    logic [ROWS-1:0] addr_q;
    logic [DW-1:0]   data_q;
    logic [ID_W-1:0] id_q;
    logic [DW-1:0]   row_rd;
    logic            verify_ok;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= pin_sclk;
    end
    assign rise = pin_sclk & ~sclk_q;

    isp_fsm u_fsm (
        .clk(clk), .rst(rst), .en_n(prog_en_n), .rise(rise),
        .mode(pin_mode), .sdi(pin_sdi),
        .state_o(state), .instr_o(instr), .shift_o(shift), .cmd_o(cmd)
    );

    isp_sreg #(.W(ROWS)) u_addr (
        .clk(clk), .rst(rst), .shift_en(shift.addr), .load_en(1'b0),
        .load_val('0), .sdi(pin_sdi), .q(addr_q)
    );

    assign verify_ok = cmd.verify && ($countones(addr_q) == 1);

    isp_sreg #(.W(DW)) u_data (
        .clk(clk), .rst(rst), .shift_en(shift.data), .load_en(verify_ok),
        .load_val(row_rd), .sdi(pin_sdi), .q(data_q)
    );

    isp_sreg #(.W(ID_W)) u_id (
        .clk(clk), .rst(rst), .shift_en(shift.id), .load_en(cmd.readid),
        .load_val(ID_VAL), .sdi(pin_sdi), .q(id_q)
    );

    isp_array #(.ROWS(ROWS), .WIDTH(DW)) u_array (
        .clk(clk), .rst(rst), .wr_en(cmd.prog), .row_sel(addr_q),
        .wdata(data_q), .rdata(row_rd)
    );

    always_comb begin
        sdo = 1'b0;
        if (state == ST_SHIFT) begin
            case (instr)
                OP_ADDR:   sdo = addr_q[0];
                OP_DATA:   sdo = data_q[0];
                OP_READID: sdo = id_q[0];
                default:   sdo = 1'b0;
            endcase
        end
    end

    assign sdo_oe  = ~prog_en_n;
    assign user_in = prog_en_n ? {pin_sclk, pin_sdo_in, pin_mode, pin_sdi} : 4'b0;

endmodule

// File: rtl/isp_ctrl_chk.sv
module isp_ctrl_chk
    import isp_pkg::*;
#(
    parameter int ROWS = 108,
    parameter int DW   = 320,
    parameter int ID_W = 8,
    parameter logic [ID_W-1:0] ID_VAL = 8'h03
) (
    input logic            clk,
    input logic            rst,
    input logic            en_n,
    input logic            mode,
    input logic            sdi,
    input logic            rise,
    input logic            sdo,
    input logic [3:0]      user_in,
    input isp_state_e      state,
    input logic [OP_W-1:0] instr,
    input logic [ROWS-1:0] addr_q,
    input logic [DW-1:0]   data_q,
    input logic [ID_W-1:0] id_q
);

    assert_gate_R1: assert property (@(posedge clk) disable iff (rst)
        !en_n |-> user_in == 4'b0);

    assert_frozen_R1: assert property (@(posedge clk) disable iff (rst)
        en_n |=> ($stable(addr_q) && $stable(data_q) && $stable(id_q)));

    assert_instr_R3: assert property (@(posedge clk) disable iff (rst)
        (rise && !en_n && !mode && state == ST_IDLE) |=> instr[OP_W-1] == $past(sdi));

    assert_addr_shift_R5: assert property (@(posedge clk) disable iff (rst)
        (rise && !en_n && !mode && state == ST_SHIFT && instr == OP_ADDR)
        |=> (addr_q[ROWS-1] == $past(sdi)) && (addr_q[ROWS-2:0] == $past(addr_q[ROWS-1:1])));

    assert_id_load_R9: assert property (@(posedge clk) disable iff (rst)
        (rise && !en_n && mode && sdi && state == ST_SHIFT && instr == OP_READID)
        |=> id_q == ID_VAL);

    assert_release_R10: assert property (@(posedge clk) disable iff (rst)
        en_n |=> (state == ST_IDLE && instr == '0));

    assert_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        state != ST_SHIFT |-> !sdo);

endmodule

bind isp_ctrl isp_ctrl_chk #(
    .ROWS(ROWS), .DW(2*HALF), .ID_W(ID_W), .ID_VAL(ID_VAL)
) u_chk (
    .clk(clk), .rst(rst), .en_n(prog_en_n), .mode(pin_mode), .sdi(pin_sdi),
    .rise(rise), .sdo(sdo), .user_in(user_in), .state(state), .instr(instr),
    .addr_q(addr_q), .data_q(data_q), .id_q(id_q)
);

// File: tb/tb_isp_ctrl.sv
module tb_isp_ctrl;

    localparam int ROWS = 108;
    localparam int DW   = 320;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic prog_en_n = 1'b1;
    logic pin_sdi = 1'b0, pin_mode = 1'b0, pin_sdo_in = 1'b0, pin_sclk = 1'b0;
    logic sdo, sdo_oe;
    logic [3:0] user_in;

    always #2.5 clk = ~clk;

    isp_ctrl dut (
        .clk(clk), .rst(rst), .prog_en_n(prog_en_n), .pin_sdi(pin_sdi),
        .pin_mode(pin_mode), .pin_sdo_in(pin_sdo_in), .pin_sclk(pin_sclk),
        .sdo(sdo), .sdo_oe(sdo_oe), .user_in(user_in)
    );

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference
    int       m_st = 0;        // 0 idle, 1 shift, 2 execute
    bit [4:0] m_op = '0;
    bit [ROWS-1:0] m_addr = '0;
    bit [DW-1:0]   m_data = '0;
    bit [7:0]      m_id = '0;
    bit [DW-1:0]   m_mem [ROWS];

    task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    function automatic bit exp_sdo();
        if (m_st != 1) return 1'b0;
        case (m_op)
            5'd1:    return m_addr[0];
            5'd2:    return m_data[0];
            5'd5:    return m_id[0];
            default: return 1'b0;
        endcase
    endfunction

    task automatic compare();
        logic [3:0] exp_u;
        exp_u = prog_en_n ? {pin_sclk, pin_sdo_in, pin_mode, pin_sdi} : 4'b0;
        chk(sdo === exp_sdo(), "sdo", {31'b0, sdo}, {31'b0, exp_sdo()});
        chk(sdo_oe === !prog_en_n, "sdo_oe R2", {31'b0, sdo_oe}, {31'b0, !prog_en_n});
        chk(user_in === exp_u, "user_in R1", {28'b0, user_in}, {28'b0, exp_u});
    endtask

    task automatic model_exec();
        int cnt, idx;
        case (m_op)
            5'd3: for (int r = 0; r < ROWS; r++) if (m_addr[r]) m_mem[r] = m_data;
            5'd4: begin
                cnt = 0; idx = 0;
                for (int r = 0; r < ROWS; r++) if (m_addr[r]) begin cnt++; idx = r; end
                if (cnt == 1) m_data = m_mem[idx];
            end
            5'd5: m_id = 8'h03;
            default: ;
        endcase
    endtask

    task automatic model_step(bit m, bit s);
        if (prog_en_n) return;
        if (m) begin
            if (m_st == 1 && s) model_exec();
            case (m_st)
                0:       m_st = s ? 1 : 0;
                1:       m_st = s ? 2 : 0;
                default: m_st = s ? 1 : 0;
            endcase
        end else if (m_st == 0) begin
            m_op = {s, m_op[4:1]};
        end else if (m_st == 1) begin
            case (m_op)
                5'd1: m_addr = {s, m_addr[ROWS-1:1]};
                5'd2: m_data = {s, m_data[DW-1:1]};
                5'd5: m_id   = {s, m_id[7:1]};
                default: ;
            endcase
        end
    endtask

    // one serial-clock period, compared on both system clocks
    task automatic pulse(bit m, bit s);
        pin_mode = m; pin_sdi = s; pin_sclk = 1'b1;
        @(negedge clk);
        model_step(m, s);
        compare();
        pin_sclk = 1'b0;
        @(negedge clk);
        compare();
    endtask

    task automatic set_en(bit v);
        prog_en_n = v;
        if (v) begin m_st = 0; m_op = '0; end
        @(negedge clk);
        compare();
    endtask

    task automatic send_op(bit [4:0] op);
        for (int i = 0; i < 5; i++) pulse(1'b0, op[i]);
    endtask

    task automatic load_reg(bit [4:0] op, int n, bit [DW-1:0] v);
        send_op(op);
        pulse(1'b1, 1'b1);
        for (int b = 0; b < n; b++) pulse(1'b0, v[b]);
        pulse(1'b1, 1'b0);
    endtask

    task automatic run_cmd(bit [4:0] op);
        send_op(op);
        pulse(1'b1, 1'b1);
        pulse(1'b1, 1'b1);
        pulse(1'b1, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bit [DW-1:0] pat_a, pat_b;
        bit [ROWS-1:0] sel;
        for (int r = 0; r < ROWS; r++) m_mem[r] = '0;
        for (int b = 0; b < DW; b++) begin
            pat_a[b] = ((b % 3) == 0) ^ (b >= 160);
            pat_b[b] = ((b % 5) == 1);
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cur_req = "R2";
        compare();

        // R1: pins pass through, serial edges ignored
        cur_req = "R1";
        for (int p = 0; p < 16; p++) begin
            pin_sdi = p[0]; pin_mode = p[1]; pin_sdo_in = p[2]; pin_sclk = p[3];
            @(negedge clk);
            compare();
        end
        pin_sclk = 1'b0; pin_sdo_in = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 12; k++) pulse(k[0], 1'b1);
        set_en(1'b0);
        cur_req = "R2";
        compare();

        // R3 / R4: instruction load and state walk without execution effect
        cur_req = "R4";
        pulse(1'b1, 1'b0);
        cur_req = "R3";
        send_op(5'd1);
        cur_req = "R5";
        pulse(1'b1, 1'b1);
        // R1: address register still zero after ignored edges
        cur_req = "R1";
        for (int b = 0; b < 4; b++) pulse(1'b0, 1'b0);
        chk(sdo === 1'b0, "addr untouched", {31'b0, sdo}, 32'd0);
        cur_req = "R4";
        pulse(1'b1, 1'b0);

        // R5: row select with rows 5 and 70
        cur_req = "R5";
        sel = '0; sel[5] = 1'b1; sel[70] = 1'b1;
        load_reg(5'd1, ROWS, {{(DW-ROWS){1'b0}}, sel});
        // R6: data pattern A
        cur_req = "R6";
        load_reg(5'd2, DW, pat_a);
        // R7: program rows 5 and 70
        cur_req = "R7";
        run_cmd(5'd3);
        // overwrite data register with pattern B, reading A back
        cur_req = "R6";
        load_reg(5'd2, DW, pat_b);
        // R8: two rows selected -> data unchanged (still B)
        cur_req = "R8";
        run_cmd(5'd4);
        load_reg(5'd2, DW, pat_b);
        // R8: single row 70 -> pattern A restored
        sel = '0; sel[70] = 1'b1;
        load_reg(5'd1, ROWS, {{(DW-ROWS){1'b0}}, sel});
        run_cmd(5'd4);
        cur_req = "R7";
        load_reg(5'd2, DW, pat_b);
        // R7: row 6 not written -> reads zero
        sel = '0; sel[6] = 1'b1;
        load_reg(5'd1, ROWS, {{(DW-ROWS){1'b0}}, sel});
        run_cmd(5'd4);
        load_reg(5'd2, DW, pat_b);
        // R8: no row selected -> unchanged
        cur_req = "R8";
        load_reg(5'd1, ROWS, '0);
        run_cmd(5'd4);
        load_reg(5'd2, DW, pat_a);

        // R9: identifier
        cur_req = "R9";
        send_op(5'd5);
        pulse(1'b1, 1'b1);
        pulse(1'b1, 1'b1);
        pulse(1'b1, 1'b1);
        chk(sdo === 1'b1, "id bit0", {31'b0, sdo}, 32'd1);
        for (int b = 0; b < 8; b++) pulse(1'b0, 1'b0);
        chk(sdo === 1'b0, "id emptied", {31'b0, sdo}, 32'd0);
        pulse(1'b1, 1'b0);

        // R11 / R12: unknown code
        cur_req = "R12";
        load_reg(5'h1F, 24, pat_b);
        run_cmd(5'h1F);
        cur_req = "R11";
        send_op(5'd3);
        pulse(1'b1, 1'b1);
        chk(sdo === 1'b0, "sdo quiet under program code", {31'b0, sdo}, 32'd0);
        pulse(1'b1, 1'b0);
        cur_req = "R12";
        load_reg(5'd2, DW, pat_b);

        // R10: release mid-shift
        cur_req = "R10";
        send_op(5'd2);
        pulse(1'b1, 1'b1);
        set_en(1'b1);
        set_en(1'b0);
        pulse(1'b1, 1'b1);
        chk(sdo === 1'b0, "instr cleared", {31'b0, sdo}, 32'd0);
        pulse(1'b1, 1'b0);
        load_reg(5'd2, DW, pat_a);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule